// File: doc/BRIEF.md
# Pulse-Counted Programming Port for an On-Chip Byte Memory

This block is the device-side engine of an external programming mode for a small byte-wide program store. A programmer outside the chip drives five slow control strobes and an 8-bit data bus. It never sends an opcode word. Instead, it selects an operation by pulsing a command-step strobe as many times as the code's value. It then confirms the operation with a low-going pulse on an execute strobe. Two more strobes clear and step the memory address. The block holds the memory itself as a behavioural array whose cells erase to all ones.

All strobes are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected in the clock domain. A session state machine guards the array with four states:
- `SES_IDLE`: no session opened yet.
- `SES_GUARDED`: session open, writes refused.
- `SES_OPEN`: unlocked, writes and lock allowed.
- `SES_SEALED`: the lock cell has been cleared; only reads are honoured.

It has five transitions:
- idle→guarded on an address-clear rise.
- guarded→open on an executed unlock.
- open→guarded on an address-clear rise.
- open→sealed on an executed lock.
- sealed stays sealed until the power-on reset.

A programmer opens a session, unlocks, then steps through addresses, writing bytes and reading them back for verification. The lock operation closes the part for good.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After `rst_n` is released, every array cell reads 8'hFF, the address and command count are zero, `data_o` is 8'h00, and `data_oe_o` and `lock_o` are low.
- R2: Each rising edge of `ctl_inc_i` adds one to the command count, which saturates at 7. A rising edge of `ctl_rst_i` clears the count to 0.
- R3: Each rising edge of `addr_inc_i` advances the address by one, wrapping modulo 2^ADDR_W. A rising edge of `addr_rst_i` clears the address to 0.
- R4: An operation runs only when `exec_n_i` returns high at the end of a low pulse, using the command count held at that moment. Stepping the count without an execute pulse changes nothing.
- R5: Code 1 (read) loads the byte at the current address onto `data_o` in every state except `SES_IDLE`.
- R6: `data_oe_o` follows the synchronised level of `ctl_rst_i`: it is high while that line is high and low otherwise.
- R7: In `SES_IDLE`, before the first rise of `addr_rst_i`, every operation is ignored. After that rise the block is in `SES_GUARDED`, where a write (code 3) leaves the array unchanged.
- R8: Code 2 moves `SES_GUARDED` to `SES_OPEN`. In `SES_OPEN`, code 3 replaces the addressed byte with the old byte AND `data_i`, so bits can only be cleared.
- R9: Code 4 in `SES_OPEN` enters `SES_SEALED` and raises `lock_o`. From then on, codes 2, 3 and 4 are ignored and reads still work. The sealed state survives an `addr_rst_i` rise.
- R10: Codes 0, 5, 6 and 7 have no effect when executed.
- R11: An `addr_rst_i` rise in `SES_OPEN` returns the block to `SES_GUARDED`, so a new unlock is needed before the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, models power-on |
| addr_rst_i | input | 1 | Address-clear strobe; a rising edge starts a session |
| addr_inc_i | input | 1 | Address-step strobe |
| ctl_rst_i | input | 1 | Command-clear strobe; its level also enables the data output |
| ctl_inc_i | input | 1 | Command-step strobe |
| exec_n_i | input | 1 | Active-low execute strobe |
| data_i | input | DATA_W | Byte to be programmed |
| data_o | output | DATA_W | Read result; contents undefined after a write |
| data_oe_o | output | 1 | Output enable for the external data bus |
| lock_o | output | 1 | High once the lock cell has been cleared |

## Verification
The assertions assume that every strobe level lasts at least three clock cycles, so each edge reaches the synchroniser output as a single rise or fall. They also assume that only one strobe changes at a time, so an address-clear never coincides with an execute. The bench holds every level for six cycles, changes one strobe at a time, and sets `data_i` before the execute pulse begins. Random stimulus mixes address steps, new sessions and command counts from 0 to 9. Directed cases cover the idle, guarded, saturated, wrapped and sealed conditions.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        SES_IDLE,
        SES_GUARDED,
        SES_OPEN,
        SES_SEALED
    } ses_state_t;

    localparam logic [CODE_W-1:0] OP_READ   = 3'd1;
    localparam logic [CODE_W-1:0] OP_UNLOCK = 3'd2;
    localparam logic [CODE_W-1:0] OP_WRITE  = 3'd3;
    localparam logic [CODE_W-1:0] OP_LOCK   = 3'd4;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int             N       = 5,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] stage_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= {2{RST_VAL[g]}};
            end else begin
                stage_q <= {stage_q[0], raw_i[g]};
            end
        end

        assign lvl_o[g] = stage_q[1];
    end

endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int W        = 3,
    parameter bit SATURATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] cnt_q;

    if (SATURATE) begin : g_sat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clr_i) begin
                cnt_q <= '0;
            end else if (inc_i && (cnt_q != {W{1'b1}})) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end else begin : g_wrap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clr_i) begin
                cnt_q <= '0;
            end else if (inc_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign q_o = cnt_q;

endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              prog_i,
    input  logic [DATA_W-1:0] prog_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    // Programming may only clear bits; erase is modelled by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= {DATA_W{1'b1}};
            end
        end else if (prog_i) begin
            cell_q[addr_i] <= cell_q[addr_i] & prog_data_i;
        end
    end

    assign rd_data_o = cell_q[addr_i];

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_rst_i,
    input  logic              addr_inc_i,
    input  logic              ctl_rst_i,
    input  logic              ctl_inc_i,
    input  logic              exec_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              lock_o
);

    localparam int NSTB         = 5;
    localparam int IX_ADDR_RST  = 0;
    localparam int IX_ADDR_INC  = 1;
    localparam int IX_CTL_RST   = 2;
    localparam int IX_CTL_INC   = 3;
    localparam int IX_EXEC      = 4;
    localparam logic [NSTB-1:0] STB_IDLE = NSTB'(1) << IX_EXEC;

    // Strobe synchronisation and edge detection
    logic [NSTB-1:0] strb_raw;
    logic [NSTB-1:0] strb_lvl;
    logic [NSTB-1:0] strb_prev_q;
    logic [NSTB-1:0] strb_rise;

    assign strb_raw = {exec_n_i, ctl_inc_i, ctl_rst_i, addr_inc_i, addr_rst_i};

    strobe_sync #(
        .N       (NSTB),
        .RST_VAL (STB_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (strb_raw),
        .lvl_o (strb_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_prev_q <= STB_IDLE;
        end else begin
            strb_prev_q <= strb_lvl;
        end
    end

    assign strb_rise = strb_lvl & ~strb_prev_q;

    logic addr_rst_rise;
    logic addr_inc_rise;
    logic ctl_rst_rise;
    logic ctl_inc_rise;
    logic exec_done;

    assign addr_rst_rise = strb_rise[IX_ADDR_RST];
    assign addr_inc_rise = strb_rise[IX_ADDR_INC];
    assign ctl_rst_rise  = strb_rise[IX_CTL_RST];
    assign ctl_inc_rise  = strb_rise[IX_CTL_INC];
    assign exec_done     = strb_rise[IX_EXEC];

    // Command and address counters
    logic [CODE_W-1:0] ctl_q;
    logic [ADDR_W-1:0] addr_q;

    step_counter #(
        .W        (CODE_W),
        .SATURATE (1'b1)
    ) u_cmd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ctl_rst_rise),
        .inc_i (ctl_inc_rise),
        .q_o   (ctl_q)
    );

    step_counter #(
        .W        (ADDR_W),
        .SATURATE (1'b0)
    ) u_addr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (addr_rst_rise),
        .inc_i (addr_inc_rise),
        .q_o   (addr_q)
    );

    // Session state machine
    ses_state_t ses_q;
    ses_state_t ses_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ses_q <= SES_IDLE;
        end else begin
            ses_q <= ses_d;
        end
    end

    always_comb begin
        ses_d = ses_q;
        unique case (ses_q)
            SES_IDLE: begin
                if (addr_rst_rise) ses_d = SES_GUARDED;
            end
            SES_GUARDED: begin
                if (exec_done && (ctl_q == OP_UNLOCK)) ses_d = SES_OPEN;
            end
            SES_OPEN: begin
                if (addr_rst_rise) begin
                    ses_d = SES_GUARDED;
                end else if (exec_done && (ctl_q == OP_LOCK)) begin
                    ses_d = SES_SEALED;
                end
            end
            SES_SEALED: begin
                ses_d = SES_SEALED;
            end
            default: ses_d = SES_IDLE;
        endcase
    end

    // Output decode of the state machine
    logic rd_exec;
    logic wr_en;

    always_comb begin
        rd_exec = 1'b0;
        wr_en   = 1'b0;
        unique case (ses_q)
            SES_IDLE: begin
                rd_exec = 1'b0;
                wr_en   = 1'b0;
            end
            SES_GUARDED, SES_SEALED: begin
                rd_exec = exec_done && (ctl_q == OP_READ);
            end
            SES_OPEN: begin
                rd_exec = exec_done && (ctl_q == OP_READ);
                wr_en   = exec_done && (ctl_q == OP_WRITE);
            end
            default: begin
                rd_exec = 1'b0;
                wr_en   = 1'b0;
            end
        endcase
    end

    // Memory array and read register
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] out_q;

    cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_q),
        .prog_i      (wr_en),
        .prog_data_i (data_i),
        .rd_data_o   (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (rd_exec) begin
            out_q <= rd_data;
        end else if (wr_en) begin
            out_q <= '0;
        end
    end

    assign data_o    = out_q;
    assign data_oe_o = strb_lvl[IX_CTL_RST];
    assign lock_o    = (ses_q == SES_SEALED);

endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_rst_i,
    input logic              data_oe_o,
    input logic              lock_o,
    input logic [DATA_W-1:0] data_o,
    input logic [2:0]        ctl_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              ctl_inc_rise,
    input logic              ctl_rst_rise,
    input logic              addr_inc_rise,
    input logic              addr_rst_rise,
    input logic              rd_exec,
    input logic              wr_en
);

    assert_ctl_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == 3'd7 && ctl_inc_rise && !ctl_rst_rise) |=> (ctl_q == 3'd7));

    assert_ctl_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_rise |=> (ctl_q == 3'd0));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_inc_rise && !addr_rst_rise) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    assert_addr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rst_rise |=> (addr_q == '0));

    assert_oe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> $past(ctl_rst_i, 2));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_exec && !wr_en) |=> $stable(data_o));

endmodule

bind eprom_prog_ctrl eprom_prog_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_rst_i     (ctl_rst_i),
    .data_oe_o     (data_oe_o),
    .lock_o        (lock_o),
    .data_o        (data_o),
    .ctl_q         (ctl_q),
    .addr_q        (addr_q),
    .ctl_inc_rise  (ctl_inc_rise),
    .ctl_rst_rise  (ctl_rst_rise),
    .addr_inc_rise (addr_inc_rise),
    .addr_rst_rise (addr_rst_rise),
    .rd_exec       (rd_exec),
    .wr_en         (wr_en)
);

// File: tb/eprom_prog_ctrl_test.sv
module eprom_prog_ctrl_test;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_rst_i = 1'b0;
    logic          addr_inc_i = 1'b0;
    logic          ctl_rst_i = 1'b0;
    logic          ctl_inc_i = 1'b0;
    logic          exec_n_i = 1'b1;
    logic [DW-1:0] data_i = '0;
    logic [DW-1:0] data_o;
    logic          data_oe_o;
    logic          lock_o;

    always #10 clk = ~clk;

    eprom_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_rst_i (addr_rst_i),
        .addr_inc_i (addr_inc_i),
        .ctl_rst_i  (ctl_rst_i),
        .ctl_inc_i  (ctl_inc_i),
        .exec_n_i   (exec_n_i),
        .data_i     (data_i),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .lock_o     (lock_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model: 0 idle, 1 guarded, 2 open, 3 sealed
    logic [DW-1:0] m_mem [DEPTH];
    int            m_addr = 0;
    int            m_ses  = 0;

    function automatic int eff_code(int n);
        return (n > 7) ? 7 : n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic step_addr(int k);
        for (int i = 0; i < k; i++) begin
            addr_inc_i = 1'b1; settle();
            addr_inc_i = 1'b0; settle();
            m_addr = (m_addr + 1) % DEPTH;
        end
    endtask

    task automatic new_session();
        addr_rst_i = 1'b0; settle();
        addr_rst_i = 1'b1; settle();
        m_addr = 0;
        if (m_ses != 3) m_ses = 1;
    endtask

    // n command steps, optional execute, model update, read check
    task automatic do_op(int n, logic [DW-1:0] d, bit fire, string req);
        int code;
        ctl_rst_i = 1'b0; settle();
        check("R6", {31'd0, data_oe_o}, 32'd0, "oe low");
        ctl_rst_i = 1'b1; settle();
        check("R6", {31'd0, data_oe_o}, 32'd1, "oe high");
        for (int i = 0; i < n; i++) begin
            ctl_inc_i = 1'b1; settle();
            ctl_inc_i = 1'b0; settle();
        end
        data_i = d;
        if (fire) begin
            exec_n_i = 1'b0; settle();
            exec_n_i = 1'b1; settle();
            code = eff_code(n);
            case (code)
                1: if (m_ses != 0)
                       check(req, {24'd0, data_o}, {24'd0, m_mem[m_addr]}, "read byte");
                2: if (m_ses == 1) m_ses = 2;
                3: if (m_ses == 2) m_mem[m_addr] = m_mem[m_addr] & d;
                4: if (m_ses == 2) m_ses = 3;
                default: ;
            endcase
        end
        ctl_rst_i = 1'b0; settle();
    endtask

    task automatic read_check(string req);
        do_op(1, 8'h00, 1'b1, req);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        void'($urandom(32'h0000_5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        check("R1", {24'd0, data_o}, 32'd0, "data after reset");
        check("R1", {31'd0, data_oe_o}, 32'd0, "oe after reset");
        check("R1", {31'd0, lock_o}, 32'd0, "lock after reset");

        // R7 idle: read and unlock ignored
        do_op(1, 8'h00, 1'b1, "R7");
        check("R7", {24'd0, data_o}, 32'd0, "idle read ignored");
        do_op(2, 8'h00, 1'b1, "R7");

        new_session();
        read_check("R1");                         // erased cell reads FF
        do_op(3, 8'h0F, 1'b1, "R7");              // write while guarded
        read_check("R7");

        // R8 unlock, write, AND behaviour
        do_op(2, 8'h00, 1'b1, "R8");
        do_op(3, 8'h3C, 1'b1, "R8");
        read_check("R8");
        do_op(3, 8'hF0, 1'b1, "R8");
        read_check("R8");
        check("R8", {24'd0, data_o}, 32'h30, "AND result");

        // R4 stepping without execute has no effect
        do_op(3, 8'h00, 1'b0, "R4");
        read_check("R4");
        check("R4", {24'd0, data_o}, 32'h30, "no execute no write");

        // R2 saturation at 7, R10 unused codes
        do_op(9, 8'h00, 1'b1, "R2");
        do_op(5, 8'h00, 1'b1, "R10");
        do_op(6, 8'h00, 1'b1, "R10");
        do_op(0, 8'h00, 1'b1, "R10");
        read_check("R10");
        check("R2", {24'd0, data_o}, 32'h30, "saturated code no write");

        // R3 address step and wrap
        step_addr(3);
        do_op(3, 8'hA5, 1'b1, "R3");
        read_check("R3");
        step_addr(DEPTH);
        read_check("R3");
        check("R3", {24'd0, data_o}, 32'hA5, "wrap returns same cell");

        // R11 new session re-guards
        new_session();
        do_op(3, 8'h00, 1'b1, "R11");
        read_check("R11");
        check("R11", {24'd0, data_o}, 32'h30, "guarded after new session");
        do_op(2, 8'h00, 1'b1, "R11");

        // random phase
        for (int it = 0; it < 220; it++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 2) begin
                step_addr(int'($urandom_range(1, 3)));
            end else if (r == 2) begin
                new_session();
                do_op(2, 8'h00, 1'b1, "R11");
            end else begin
                int n;
                n = int'($urandom_range(0, 9));
                if (n == 4) n = 3;
                do_op(n, 8'($urandom), 1'b1, "R8");
                read_check("R5");
            end
            check("R9", {31'd0, lock_o}, {31'd0, m_ses == 3}, "lock flag");
        end

        // R9 lock and its effects
        do_op(4, 8'h00, 1'b1, "R9");
        check("R9", {31'd0, lock_o}, 32'd1, "lock set");
        do_op(3, 8'h00, 1'b1, "R9");
        read_check("R9");
        new_session();
        check("R9", {31'd0, lock_o}, 32'd1, "lock survives session");
        do_op(2, 8'h00, 1'b1, "R9");
        do_op(3, 8'h00, 1'b1, "R9");
        read_check("R9");
        step_addr(3);
        read_check("R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule